// File: doc/BRIEF.md
# Auxiliary system control registers

This block holds a handful of small control registers that a workstation I/O controller exposes on its register bus: a configuration byte, a diagnostic byte, a modem-control byte, a 16-bit LED word, a 32-bit system-control word and two auxiliary bytes. Each register lives in a window of its own, chosen by one bit of a one-hot region strobe. An access also carries an offset, a write flag, a size code and write data. Read data comes back one cycle after the access.

The auxiliary registers control power and floppy handling. The first auxiliary byte turns a written bit into a one-cycle terminal-count pulse. The second auxiliary byte holds a power-fail status bit. Only the synchronized power-fail input can set that bit. Software can clear it with a write-one-to-clear bit, and the same byte can request power-off. A write to the system-control word can request a system reset and leaves a reset-status value behind. Both requests are level outputs, and only the block reset clears them.

The block reset is selective. It clears configuration, modem control and both auxiliary bytes. The diagnostic, LED and system-control registers keep their contents, so software can inspect them after a reset that this block requested.

Top module: `aux_ctrl_regs`

## Requirements
- R1: `irq_o` is high exactly when power-fail status (second auxiliary byte, bit 5) and power-interrupt enable (configuration, bit 3) are both set. It changes on the same clock edge as either bit.
- R2: `pwr_fail_i` passes through a two-flop synchronizer. When the synchronized level changes, the status bit takes (new level AND enable) on the third rising edge after the input change. Changing the enable alone does not alter the status bit. A level change in the same cycle as a write to the second auxiliary byte decides the status bit.
- R3: A legal write to the first auxiliary byte with data bit 1 set drives `fd_tc_o` high for exactly one cycle, starting the edge after the write. The stored byte always has bit 1 at 0.
- R4: A write to the second auxiliary byte stores only data bits 0 and 1, plus the current status bit 5. A write can never set bit 5.
- R5: If data bit 1 of a second-auxiliary write is set, the stored value keeps only data bit 0. This clears both the status bit and bit 1.
- R6: Once bit 0 of the second auxiliary byte is stored as 1, `pwr_off_o` rises and stays high until reset.
- R7: A legal write to the system-control word with data bit 0 set stores 0x02 in it and raises `sys_rst_o`, which stays high until reset. With bit 0 clear the write changes nothing.
- R8: Reset clears configuration, modem control, both auxiliary bytes and all four outputs. It leaves the diagnostic byte, the LED word and the system-control word unchanged.
- R9: Size codes are 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes. The LED word needs code 1, the system-control word needs code 2, and every other register needs code 0. With any other code a write is ignored and a read returns 0.
- R10: Every register sits at offset 0 of its window. A write at a nonzero offset is ignored, and a read there returns 0.
- R11: Strobe bits are 0 configuration, 1 diagnostic, 2 modem control, 3 LED, 4 system control, 5 first auxiliary, 6 second auxiliary. A strobe with more than one bit set is ignored and reads 0.
- R12: A legal read returns the register zero-extended on `rdata_o` in the cycle after the access. `rdata_o` is 0 after any cycle without a legal read. Configuration, diagnostic, modem control and LED read back the full value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rgn_stb | input | 7 | One-hot region strobe, one bit per register window |
| bus_addr | input | 2 | Byte offset inside the selected window |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size code |
| bus_wdata | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pwr_fail_i | input | 1 | Asynchronous power-fail level |
| irq_o | output | 1 | Power-fail interrupt |
| fd_tc_o | output | 1 | Floppy terminal-count pulse |
| pwr_off_o | output | 1 | Sticky power-off request |
| sys_rst_o | output | 1 | Sticky system-reset request |

## Verification
The assertions check on every cycle the following properties:
- The interrupt always matches status AND enable.
- The status bit only rises after a synchronized power-fail change.
- A clear write leaves status and bit 1 low.
- Both requests are sticky.
- Each terminal-count pulse traces back to a qualifying write.
- Wrongly sized or offset accesses leave the LED and system-control registers stable.

The bench scenarios cover the remaining behaviour:
- the synchronizer latency;
- the ordering of the status bit against the enable and the clear bit;
- the exact values read back;
- the selective effect of reset, which keeps diagnostic, LED and system-control contents while clearing the rest.

// File: rtl/auxr_pkg.sv
package auxr_pkg;
  localparam int NUM_RGN = 7;

  // region strobe bit positions
  localparam int I_CFG  = 0;
  localparam int I_DIAG = 1;
  localparam int I_MDM  = 2;
  localparam int I_LED  = 3;
  localparam int I_SYS  = 4;
  localparam int I_AUX1 = 5;
  localparam int I_AUX2 = 6;

  // access size codes
  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;
  localparam logic [1:0] SZ_W = 2'd2;

  // field positions
  localparam int CFG_PIE  = 3;
  localparam int AUX1_TC  = 1;
  localparam int AUX2_OFF = 0;
  localparam int AUX2_CLR = 1;
  localparam int AUX2_PF  = 5;
  localparam int SYS_REQ  = 0;
  localparam logic [7:0] SYS_STAT = 8'h02;

  function automatic logic [1:0] rgn_size(int idx);
    case (idx)
      I_LED:   return SZ_H;
      I_SYS:   return SZ_W;
      default: return SZ_B;
    endcase
  endfunction
endpackage

// File: rtl/aux_sync.sv
module aux_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] shf;

  always_ff @(posedge clk) begin
    if (rst) shf <= '0;
    else     shf <= {shf[STAGES-2:0], d_i};
  end

  assign q_o = shf[STAGES-1];
endmodule

// File: rtl/aux_decode.sv
module aux_decode
  import auxr_pkg::*;
#(
  parameter int NRGN = NUM_RGN,
  parameter int AW   = 2
) (
  input  logic [NRGN-1:0] rgn_stb,
  input  logic [AW-1:0]   addr,
  input  logic            wr,
  input  logic [1:0]      size,
  output logic [NRGN-1:0] wr_hit,
  output logic [NRGN-1:0] rd_hit
);
  logic            single;
  logic [NRGN-1:0] ok;

  // exactly one strobe bit set
  assign single = (rgn_stb != '0) && ((rgn_stb & (rgn_stb - 1'b1)) == '0);

  for (genvar g = 0; g < NRGN; g++) begin : g_rgn
    assign ok[g] = single && rgn_stb[g] && (addr == '0) && (size == rgn_size(g));
  end

  assign wr_hit = ok & {NRGN{wr}};
  assign rd_hit = ok & {NRGN{~wr}};
endmodule

// File: rtl/aux_pwr.sv
module aux_pwr
  import auxr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pf_lvl,
  input  logic       en_q,
  input  logic       en_n,
  input  logic       wr,
  input  logic [1:0] wd,
  output logic [7:0] aux2_q,
  output logic       irq_o,
  output logic       off_o
);
  logic       pf_d;
  logic       chg;
  logic [7:0] nxt;

  assign chg = pf_lvl ^ pf_d;

  always_comb begin
    nxt = aux2_q;
    if (wr) begin
      nxt = '0;
      nxt[AUX2_OFF] = wd[0];
      nxt[AUX2_CLR] = wd[1];
      nxt[AUX2_PF]  = aux2_q[AUX2_PF];
      if (wd[1]) begin
        nxt[AUX2_CLR] = 1'b0;
        nxt[AUX2_PF]  = 1'b0;
      end
    end
    if (chg) nxt[AUX2_PF] = pf_lvl & en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aux2_q <= '0;
      irq_o  <= 1'b0;
      off_o  <= 1'b0;
      pf_d   <= 1'b0;
    end else begin
      aux2_q <= nxt;
      irq_o  <= nxt[AUX2_PF] & en_n;
      off_o  <= off_o | nxt[AUX2_OFF];
      pf_d   <= pf_lvl;
    end
  end

  a_r1_irq_match: assert property (@(posedge clk) disable iff (rst)
    irq_o == (aux2_q[AUX2_PF] & en_q));

  a_r4_no_sw_set: assert property (@(posedge clk) disable iff (rst)
    $rose(aux2_q[AUX2_PF]) |-> $past(chg));

  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    $past(wr && wd[1] && !chg) |-> (!aux2_q[AUX2_PF] && !aux2_q[AUX2_CLR]));

  a_r6_off_sticky: assert property (@(posedge clk) disable iff (rst)
    ($past(off_o) && !$past(rst)) |-> off_o);

  a_r6_off_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(off_o) |-> aux2_q[AUX2_OFF]);
endmodule

// File: rtl/aux_ctrl_regs.sv
module aux_ctrl_regs
  import auxr_pkg::*;
#(
  parameter int DW          = 32,
  parameter int AW          = 2,
  parameter int LW          = 16,
  parameter int BW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_RGN-1:0] rgn_stb,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_wr,
  input  logic [1:0]         bus_size,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      rdata_o,
  input  logic               pwr_fail_i,
  output logic               irq_o,
  output logic               fd_tc_o,
  output logic               pwr_off_o,
  output logic               sys_rst_o
);
  logic [NUM_RGN-1:0] wr_hit, rd_hit;
  logic [BW-1:0] cfg_q, cfg_n, mdm_q, aux1_q, aux2_q;
  logic [BW-1:0] diag_q = '0;
  logic [BW-1:0] sys_q  = '0;
  logic [LW-1:0] led_q  = '0;
  logic [DW-1:0] rd_n;
  logic          pf_lvl;
  logic          unused_hi;

  assign unused_hi = ^bus_wdata[DW-1:LW];

  aux_decode #(.NRGN(NUM_RGN), .AW(AW)) u_dec (
    .rgn_stb(rgn_stb), .addr(bus_addr), .wr(bus_wr), .size(bus_size),
    .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  aux_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(pwr_fail_i), .q_o(pf_lvl)
  );

  assign cfg_n = wr_hit[I_CFG] ? bus_wdata[BW-1:0] : cfg_q;

  aux_pwr u_pwr (
    .clk(clk), .rst(rst), .pf_lvl(pf_lvl),
    .en_q(cfg_q[CFG_PIE]), .en_n(cfg_n[CFG_PIE]),
    .wr(wr_hit[I_AUX2]), .wd(bus_wdata[1:0]),
    .aux2_q(aux2_q), .irq_o(irq_o), .off_o(pwr_off_o)
  );

  // registers cleared by reset
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      mdm_q     <= '0;
      aux1_q    <= '0;
      fd_tc_o   <= 1'b0;
      sys_rst_o <= 1'b0;
      rdata_o   <= '0;
    end else begin
      cfg_q   <= cfg_n;
      rdata_o <= rd_n;
      if (wr_hit[I_MDM]) mdm_q <= bus_wdata[BW-1:0];
      if (wr_hit[I_AUX1]) begin
        aux1_q          <= bus_wdata[BW-1:0];
        aux1_q[AUX1_TC] <= 1'b0;
      end
      fd_tc_o <= wr_hit[I_AUX1] & bus_wdata[AUX1_TC];
      if (wr_hit[I_SYS] && bus_wdata[SYS_REQ]) sys_rst_o <= 1'b1;
    end
  end

  // registers that keep their contents through reset
  always_ff @(posedge clk) begin
    if (wr_hit[I_DIAG]) diag_q <= bus_wdata[BW-1:0];
    if (wr_hit[I_LED])  led_q  <= bus_wdata[LW-1:0];
    if (wr_hit[I_SYS] && bus_wdata[SYS_REQ]) sys_q <= SYS_STAT;
  end

  always_comb begin
    rd_n = '0;
    if (rd_hit[I_CFG])  rd_n[BW-1:0] = cfg_q;
    if (rd_hit[I_DIAG]) rd_n[BW-1:0] = diag_q;
    if (rd_hit[I_MDM])  rd_n[BW-1:0] = mdm_q;
    if (rd_hit[I_LED])  rd_n[LW-1:0] = led_q;
    if (rd_hit[I_SYS])  rd_n[BW-1:0] = sys_q;
    if (rd_hit[I_AUX1]) rd_n[BW-1:0] = aux1_q;
    if (rd_hit[I_AUX2]) rd_n[BW-1:0] = aux2_q;
  end

  a_r3_tc_cause: assert property (@(posedge clk) disable iff (rst)
    fd_tc_o |-> $past(wr_hit[I_AUX1] && bus_wdata[AUX1_TC]));

  a_r3_tc_bit_low: assert property (@(posedge clk) disable iff (rst)
    !aux1_q[AUX1_TC]);

  a_r7_req_stat: assert property (@(posedge clk) disable iff (rst)
    sys_rst_o |-> (sys_q == SYS_STAT));

  a_r9_led_size: assert property (@(posedge clk) disable iff (rst)
    (rgn_stb[I_LED] && bus_size != SZ_H) |=> $stable(led_q));

  a_r10_sys_offset: assert property (@(posedge clk) disable iff (rst)
    (bus_addr != '0) |=> $stable(sys_q));

  a_r12_rd_idle: assert property (@(posedge clk) disable iff (rst)
    ((rgn_stb == '0) || bus_wr) |=> (rdata_o == '0));
endmodule

// File: tb/sim_aux_ctrl_regs.sv
`timescale 1ns/1ps
module sim_aux_ctrl_regs;
  logic        clk = 0;
  logic        rst = 1;
  logic [6:0]  rgn_stb = '0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_o;
  logic        pwr_fail_i = 0;
  logic        irq_o, fd_tc_o, pwr_off_o, sys_rst_o;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  // bench model
  logic [7:0]  m_cfg, m_diag, m_mdm, m_aux1, m_aux2, m_sys;
  logic [15:0] m_led;
  bit          m_off, m_rq;

  always #5 clk = ~clk;

  aux_ctrl_regs u0 (
    .clk(clk), .rst(rst), .rgn_stb(rgn_stb), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .rdata_o(rdata_o), .pwr_fail_i(pwr_fail_i), .irq_o(irq_o),
    .fd_tc_o(fd_tc_o), .pwr_off_o(pwr_off_o), .sys_rst_o(sys_rst_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [1:0] req_size(int i);
    return (i == 3) ? 2'd1 : (i == 4) ? 2'd2 : 2'd0;
  endfunction

  function automatic int idx_of(logic [6:0] s);
    for (int i = 0; i < 7; i++) if (s[i]) return i;
    return 0;
  endfunction

  function automatic bit legal(logic [6:0] s, logic [1:0] a, logic [1:0] sz);
    return $onehot(s) && a == 0 && sz == req_size(idx_of(s));
  endfunction

  function automatic logic [31:0] exp_rd(logic [6:0] s, logic [1:0] a, logic [1:0] sz);
    if (!legal(s, a, sz)) return 32'h0;
    case (idx_of(s))
      0: return {24'h0, m_cfg};
      1: return {24'h0, m_diag};
      2: return {24'h0, m_mdm};
      3: return {16'h0, m_led};
      4: return {24'h0, m_sys};
      5: return {24'h0, m_aux1};
      default: return {24'h0, m_aux2};
    endcase
  endfunction

  // one bus access, model update and output checks
  task automatic op(input logic [6:0] s, input logic [1:0] a, input logic [1:0] sz,
                    input bit w, input logic [31:0] d, input string req);
    logic [31:0] er;
    logic [7:0]  v;
    bit          etc;
    er  = w ? 32'h0 : exp_rd(s, a, sz);
    etc = 0;
    @(negedge clk);
    rgn_stb = s; bus_addr = a; bus_size = sz; bus_wr = w; bus_wdata = d;
    @(negedge clk);
    rgn_stb = '0; bus_wr = 0;
    if (w && legal(s, a, sz)) begin
      case (idx_of(s))
        0: m_cfg  = d[7:0];
        1: m_diag = d[7:0];
        2: m_mdm  = d[7:0];
        3: m_led  = d[15:0];
        4: if (d[0]) begin m_sys = 8'h02; m_rq = 1; end
        5: begin m_aux1 = d[7:0] & 8'hFD; etc = d[1]; end
        default: begin
          v = (d[7:0] & 8'h03) | (m_aux2 & 8'h20);
          if (v[1]) v = v & 8'h01;
          m_aux2 = v;
          if (v[0]) m_off = 1;
        end
      endcase
    end
    chk({req, " rdata"}, rdata_o, er);
    chk("R3 tc", {31'h0, fd_tc_o}, {31'h0, etc});
    chk("R1 irq", {31'h0, irq_o}, {31'h0, m_aux2[5] & m_cfg[3]});
    chk("R6 off", {31'h0, pwr_off_o}, {31'h0, m_off});
    chk("R7 rq", {31'h0, sys_rst_o}, {31'h0, m_rq});
  endtask

  task automatic set_pf(input bit lvl);
    @(negedge clk);
    pwr_fail_i = lvl;
    repeat (5) @(negedge clk);
    m_aux2[5] = lvl & m_cfg[3];
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk); rst = 0;
    m_cfg = 0; m_mdm = 0; m_aux1 = 0; m_aux2 = 0; m_off = 0; m_rq = 0;
  endtask

  localparam logic [6:0] S_CFG = 7'b0000001, S_DIAG = 7'b0000010, S_MDM = 7'b0000100,
                         S_LED = 7'b0001000, S_SYS = 7'b0010000, S_AUX1 = 7'b0100000,
                         S_AUX2 = 7'b1000000;

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    m_cfg = 0; m_diag = 0; m_mdm = 0; m_aux1 = 0; m_aux2 = 0;
    m_sys = 0; m_led = 0; m_off = 0; m_rq = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R8 reset state
    chk("R8 irq", {31'h0, irq_o}, 32'h0);
    chk("R8 off", {31'h0, pwr_off_o}, 32'h0);
    chk("R8 rq", {31'h0, sys_rst_o}, 32'h0);
    chk("R8 tc", {31'h0, fd_tc_o}, 32'h0);
    op(S_CFG, 0, 0, 0, 0, "R8 cfg");

    // R12 full readback, R3 pulse
    op(S_CFG, 0, 0, 1, 32'hF7, "R12");
    op(S_CFG, 0, 0, 0, 0, "R12 cfg");
    op(S_MDM, 0, 0, 1, 32'hA5, "R12");
    op(S_MDM, 0, 0, 0, 0, "R12 mdm");
    op(S_AUX1, 0, 0, 1, 32'hFF, "R3");
    op(S_AUX1, 0, 0, 0, 0, "R3 aux1");
    op(S_AUX1, 0, 0, 1, 32'h41, "R3");
    // R9 wrong size, R10 offset, R11 multi strobe
    op(S_LED, 0, 1, 1, 32'h0000BEEF, "R9");
    op(S_LED, 0, 0, 1, 32'h00001111, "R9");
    op(S_LED, 0, 2, 0, 0, "R9 led size");
    op(S_LED, 0, 1, 0, 0, "R9 led");
    op(S_LED, 2, 1, 1, 32'h2222, "R10");
    op(S_LED, 2, 1, 0, 0, "R10 led off");
    op(S_LED, 0, 1, 0, 0, "R10 led");
    op(S_DIAG, 0, 0, 1, 32'h3C, "R12");
    op(7'b0000011, 0, 0, 1, 32'hAA, "R11");
    op(7'b0000011, 0, 0, 0, 0, "R11 rd");
    op(S_DIAG, 0, 0, 0, 0, "R11 diag");
    op(S_CFG, 0, 0, 0, 0, "R11 cfg");
    // R7
    op(S_SYS, 0, 2, 1, 32'hFFFF_FFFE, "R7");
    op(S_SYS, 0, 2, 0, 0, "R7 nochange");
    op(S_SYS, 1, 2, 1, 32'h1, "R10");
    op(S_SYS, 0, 2, 0, 0, "R10 sys");
    op(S_SYS, 0, 0, 1, 32'h1, "R9");
    op(S_SYS, 0, 2, 0, 0, "R9 sys");

    // R2/R4/R5 power-fail sequences
    op(S_CFG, 0, 0, 1, 32'h08, "R1");
    set_pf(1);
    chk("R2 irq", {31'h0, irq_o}, 32'h1);
    op(S_AUX2, 0, 0, 0, 0, "R2 stat");
    op(S_AUX2, 0, 0, 1, 32'hDC, "R4");
    op(S_AUX2, 0, 0, 0, 0, "R4 aux2");
    op(S_AUX2, 0, 0, 1, 32'h22, "R5");
    op(S_AUX2, 0, 0, 0, 0, "R5 aux2");
    set_pf(0);
    op(S_AUX2, 0, 0, 0, 0, "R2 low");
    op(S_CFG, 0, 0, 1, 32'h00, "R2");
    set_pf(1);
    op(S_AUX2, 0, 0, 0, 0, "R2 disabled");
    op(S_CFG, 0, 0, 1, 32'h08, "R2");
    op(S_AUX2, 0, 0, 0, 0, "R2 enable only");
    set_pf(0);
    set_pf(1);
    op(S_CFG, 0, 0, 1, 32'h00, "R1");
    op(S_CFG, 0, 0, 1, 32'h08, "R1");
    set_pf(0);
    op(S_AUX2, 0, 0, 0, 0, "R2 fall");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int i;
      logic [1:0] a, sz;
      i  = $urandom % 7;
      a  = ($urandom % 5 == 0) ? 2'($urandom % 4) : 2'd0;
      sz = ($urandom % 4 == 0) ? 2'($urandom % 4) : req_size(i);
      op(7'(1 << i), a, sz, bit'($urandom % 2), $urandom, "R12");
    end

    // R8 selective reset and R6 power-off
    op(S_DIAG, 0, 0, 1, 32'h5A, "R8");
    op(S_LED, 0, 1, 1, 32'h1234, "R8");
    op(S_SYS, 0, 2, 1, 32'h1, "R7");
    op(S_MDM, 0, 0, 1, 32'h33, "R8");
    op(S_AUX1, 0, 0, 1, 32'h85, "R8");
    op(S_AUX2, 0, 0, 1, 32'h01, "R6");
    op(S_AUX2, 0, 0, 1, 32'h00, "R6");
    do_reset();
    chk("R8 off", {31'h0, pwr_off_o}, 32'h0);
    chk("R8 rq", {31'h0, sys_rst_o}, 32'h0);
    op(S_CFG, 0, 0, 0, 0, "R8 cfg");
    op(S_MDM, 0, 0, 0, 0, "R8 mdm");
    op(S_AUX1, 0, 0, 0, 0, "R8 aux1");
    op(S_AUX2, 0, 0, 0, 0, "R8 aux2");
    op(S_DIAG, 0, 0, 0, 0, "R8 diag");
    op(S_LED, 0, 1, 0, 0, "R8 led");
    op(S_SYS, 0, 2, 0, 0, "R8 sys");

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule